// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a register-mapped general-purpose I/O controller for 128 pins, split into four banks of 32. Software programs each pin as input or output with a direction word. It drives output pins through a latch that is changed only by write-one-to-set and write-one-to-clear words. It reads back the live pin state through a level word. Each bank also keeps two alternate-function words. These words are plain storage and do not route any pin.

Register offsets fall inside a 512-byte window, and the map is not linear. The first three banks sit together at the bottom of the window. The fourth bank's level, direction, set and clear words sit in a separate region starting at 0x100. The alternate-function words of all four banks are interleaved in one run. The bus is a simple synchronous one: one access per cycle, with read data registered. A notify strobe pulses whenever a level word is read, so that neighbouring logic can refresh the pin inputs it supplies.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every direction word and output latch is zero, `pin_out` is zero, `bus_rdata` is zero and `lvl_rd_pulse` is low.
- R2: Pin n belongs to bank n>>5 at bit position n&31; it appears at `pin_out[n]` and at bit n&31 of that bank's words.
- R3: Direction words sit at 0x00C, 0x010, 0x014 (banks 0 to 2) and 0x10C (bank 3). They are read/write, and a bit value of 1 makes the pin an output.
- R4: A write to a set word (0x018, 0x01C, 0x020, 0x118) ORs the write data into that bank's output latch.
- R5: A write to a clear word (0x024, 0x028, 0x02C, 0x124) clears every latch bit where the write data is 1 and leaves the other bits unchanged.
- R6: Reading a set or clear word returns zero.
- R7: Reading a level word (0x000, 0x004, 0x008, 0x100) returns the latch bit for pins whose direction is 1 and the `pin_in` bit for pins whose direction is 0. `pin_in` is taken at the clock edge that accepts the read.
- R8: `pin_out` equals each bank's latch ANDed with its direction word. It shows the effect of a direction, set or clear write in the cycle after the write is accepted.
- R9: The alternate-function words are read/write storage. The low words are at 0x054, 0x05C, 0x064, 0x06C and the high words are at 0x058, 0x060, 0x068, 0x070, for banks 0 to 3. Writing them has no effect on `pin_out`.
- R10: A read at an offset of 0x200 or above, or at any offset not listed in R3 to R9, returns zero. A write there changes no register.
- R11: `lvl_rd_pulse` is high for exactly the cycle after each accepted level-word read, and low after any other access or idle cycle.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 128 | Input pin levels |
| pin_out | output | 128 | Driven output pin levels |
| lvl_rd_pulse | output | 1 | One-cycle strobe after a level-word read |

## Verification
A corrupted latch or direction bit shows up on `pin_out` in the very next cycle. It is also visible one cycle after any level read of that bank. A decode fault that lands a write in the wrong bank or word is caught by reading back all four banks after each write pattern. It shows as a wrong word one cycle after the read. A sweep that drives one pin at a time over all 128 pins exposes any misplaced bit within a cycle of the set write. Aliasing of out-of-window offsets shows up when the target word is read back after the stray write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int GPIO_BANKS  = 4;
    localparam int GPIO_WORD_W = 32;
    localparam int BANK_IDX_W  = $clog2(GPIO_BANKS);
    localparam int WINDOW_W    = 9;   // 512-byte window

    typedef enum logic [2:0] {
        RK_NONE,
        RK_LEVEL,
        RK_DIR,
        RK_SET,
        RK_CLR,
        RK_AF_LO,
        RK_AF_HI
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [BANK_IDX_W-1:0] bank;
    } reg_sel_t;

    // Map an in-window byte offset onto a register kind and bank.
    function automatic reg_sel_t map_offset(input logic [WINDOW_W-1:0] off);
        reg_sel_t   sel;
        logic [5:0] word;
        logic [5:0] idx;
        sel.kind = RK_NONE;
        sel.bank = '0;
        word     = off[7:2];
        idx      = '0;
        if (off[1:0] == 2'b00) begin
            if (!off[8]) begin
                if (word < 6'd3) begin
                    sel.kind = RK_LEVEL; sel.bank = word[BANK_IDX_W-1:0];
                end else if (word < 6'd6) begin
                    idx = word - 6'd3;
                    sel.kind = RK_DIR; sel.bank = idx[BANK_IDX_W-1:0];
                end else if (word < 6'd9) begin
                    idx = word - 6'd6;
                    sel.kind = RK_SET; sel.bank = idx[BANK_IDX_W-1:0];
                end else if (word < 6'd12) begin
                    idx = word - 6'd9;
                    sel.kind = RK_CLR; sel.bank = idx[BANK_IDX_W-1:0];
                end else if (word >= 6'd21 && word <= 6'd28) begin
                    idx = word - 6'd21;
                    sel.kind = idx[0] ? RK_AF_HI : RK_AF_LO;
                    sel.bank = idx[BANK_IDX_W:1];
                end
            end else begin
                sel.bank = BANK_IDX_W'(GPIO_BANKS - 1);
                case (word)
                    6'd0:    sel.kind = RK_LEVEL;
                    6'd3:    sel.kind = RK_DIR;
                    6'd6:    sel.kind = RK_SET;
                    6'd9:    sel.kind = RK_CLR;
                    default: sel.kind = RK_NONE;
                endcase
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int HI_W = ADDR_W - WINDOW_W;

    logic in_window;

    always_comb begin
        in_window = (addr[ADDR_W-1:WINDOW_W] == HI_W'(0));
        sel       = map_offset(addr[WINDOW_W-1:0]);
        if (!in_window) begin
            sel.kind = RK_NONE;
            sel.bank = '0;
        end
    end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = GPIO_WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir,
    output logic [W-1:0] latch,
    output logic [W-1:0] af_lo,
    output logic [W-1:0] af_hi
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] latch;
        logic [W-1:0] af_lo;
        logic [W-1:0] af_hi;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (kind)
                RK_DIR:   st_d.dir   = wdata;
                RK_SET:   st_d.latch = st_q.latch | wdata;
                RK_CLR:   st_d.latch = st_q.latch & ~wdata;
                RK_AF_LO: st_d.af_lo = wdata;
                RK_AF_HI: st_d.af_hi = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir   = st_q.dir;
    assign latch = st_q.latch;
    assign af_lo = st_q.af_lo;
    assign af_hi = st_q.af_hi;

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = GPIO_WORD_W,
    localparam int NUM_PINS = GPIO_BANKS * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                lvl_rd_pulse
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              pulse;
    } rd_state_t;

    reg_sel_t          sel;
    logic [DATA_W-1:0] dir_w   [GPIO_BANKS];
    logic [DATA_W-1:0] latch_w [GPIO_BANKS];
    logic [DATA_W-1:0] aflo_w  [GPIO_BANKS];
    logic [DATA_W-1:0] afhi_w  [GPIO_BANKS];
    logic [DATA_W-1:0] in_w    [GPIO_BANKS];
    rd_state_t         rd_d, rd_q;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < GPIO_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_wr && (sel.kind != RK_NONE)
                         && (sel.bank == BANK_IDX_W'(b));

        gpio_bank_regs #(.W(DATA_W)) u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bank_wr),
            .kind  (sel.kind),
            .wdata (bus_wdata),
            .dir   (dir_w[b]),
            .latch (latch_w[b]),
            .af_lo (aflo_w[b]),
            .af_hi (afhi_w[b])
        );

        assign in_w[b]                   = pin_in[b*DATA_W +: DATA_W];
        assign pin_out[b*DATA_W +: DATA_W] = latch_w[b] & dir_w[b];
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.pulse = 1'b0;
        if (bus_rd) begin
            case (sel.kind)
                RK_LEVEL: begin
                    rd_d.rdata = (latch_w[sel.bank] & dir_w[sel.bank])
                               | (in_w[sel.bank] & ~dir_w[sel.bank]);
                    rd_d.pulse = 1'b1;
                end
                RK_DIR:   rd_d.rdata = dir_w[sel.bank];
                RK_AF_LO: rd_d.rdata = aflo_w[sel.bank];
                RK_AF_HI: rd_d.rdata = afhi_w[sel.bank];
                default:  rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata    = rd_q.rdata;
    assign lvl_rd_pulse = rd_q.pulse;

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_PINS = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_rd,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic                lvl_rd_pulse
);
    reg_sel_t              csel;
    logic                  out_win;
    logic                  clr_v;
    logic [BANK_IDX_W-1:0] clr_bank;
    logic [DATA_W-1:0]     clr_mask;
    logic [DATA_W-1:0]     clr_slice;

    always_comb begin
        out_win = (bus_addr >= ADDR_W'(2**WINDOW_W));
        csel    = out_win ? reg_sel_t'('0) : map_offset(bus_addr[WINDOW_W-1:0]);
        clr_slice = pin_out[clr_bank*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_v    <= 1'b0;
            clr_bank <= '0;
            clr_mask <= '0;
        end else begin
            clr_v    <= bus_wr && !out_win && (csel.kind == RK_CLR);
            clr_bank <= csel.bank;
            clr_mask <= bus_wdata;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (pin_out == '0 && !lvl_rd_pulse));

    // R5
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_v |-> ((clr_slice & clr_mask) == '0));

    // R6
    setclr_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !out_win && (csel.kind == RK_SET || csel.kind == RK_CLR)) |=> (bus_rdata == '0));

    // R10
    outwin_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && out_win) |=> (bus_rdata == '0));

    // R11
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !out_win && csel.kind == RK_LEVEL) |=> lvl_rd_pulse);

    // R11
    pulse_only_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !out_win && csel.kind == RK_LEVEL) |=> !lvl_rd_pulse);

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .pin_out      (pin_out),
    .lvl_rd_pulse (lvl_rd_pulse)
);

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [127:0]  pin_in = '0;
    logic [127:0]  pin_out;
    logic          lvl_rd_pulse;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_dir [4];
    logic [31:0] m_lat [4];

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .lvl_rd_pulse(lvl_rd_pulse)
    );

    function automatic logic [AW-1:0] a_lvl(int b); return (b < 3) ? AW'(b*4) : AW'('h100); endfunction
    function automatic logic [AW-1:0] a_dir(int b); return a_lvl(b) + AW'('h0C); endfunction
    function automatic logic [AW-1:0] a_set(int b); return a_lvl(b) + AW'('h18); endfunction
    function automatic logic [AW-1:0] a_clr(int b); return a_lvl(b) + AW'('h24); endfunction
    function automatic logic [AW-1:0] a_aflo(int b); return AW'('h54 + 8*b); endfunction
    function automatic logic [AW-1:0] a_afhi(int b); return AW'('h58 + 8*b); endfunction

    function automatic logic [127:0] exp_out();
        logic [127:0] v = '0;
        for (int b = 0; b < 4; b++) v[b*32 +: 32] = m_lat[b] & m_dir[b];
        return v;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic p);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; p = lvl_rd_pulse;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1600000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic p;
        for (int b = 0; b < 4; b++) begin m_dir[b] = '0; m_lat[b] = '0; end

        // R1: reset state
        #20;
        chk("R1 pin_out in reset", pin_out, '0);
        chk("R1 rdata in reset", 128'(bus_rdata), '0);
        chk("R1 pulse in reset", 128'(lvl_rd_pulse), '0);
        @(negedge clk); rst_n = 1'b1;
        for (int b = 0; b < 4; b++) begin
            rd(a_dir(b), d, p);
            chk("R1 dir after reset", 128'(d), '0);
            rd(a_lvl(b), d, p);
            chk("R1 latch after reset (level, pins low)", 128'(d), '0);
        end

        // R3, R9: direction and alternate-function read/write
        for (int b = 0; b < 4; b++) begin
            m_dir[b] = 32'hA5C3_0F00 ^ (32'h1111_1111 * (b + 1));
            wr(a_dir(b), m_dir[b]);
            wr(a_aflo(b), 32'h1000_0000 + b);
            wr(a_afhi(b), 32'h2000_0000 + b);
        end
        for (int b = 0; b < 4; b++) begin
            rd(a_dir(b), d, p);
            chk("R3 direction readback", 128'(d), 128'(m_dir[b]));
            rd(a_aflo(b), d, p);
            chk("R9 af low readback", 128'(d), 128'(32'h1000_0000 + b));
            rd(a_afhi(b), d, p);
            chk("R9 af high readback", 128'(d), 128'(32'h2000_0000 + b));
        end
        chk("R9 af writes do not move pins", pin_out, exp_out());

        // R4, R5, R8: set / clear / masking
        for (int b = 0; b < 4; b++) begin
            wr(a_set(b), 32'h00FF_00FF << b);
            m_lat[b] = m_lat[b] | (32'h00FF_00FF << b);
            chk("R4 set ORs into latch", pin_out, exp_out());
            wr(a_set(b), 32'hF000_0000);
            m_lat[b] = m_lat[b] | 32'hF000_0000;
            chk("R4 second set keeps earlier bits", pin_out, exp_out());
            wr(a_clr(b), 32'h0F0F_0F0F);
            m_lat[b] = m_lat[b] & ~32'h0F0F_0F0F;
            chk("R5 clear removes only ones", pin_out, exp_out());
        end
        wr(a_dir(2), 32'h0);
        m_dir[2] = 32'h0;
        chk("R8 direction zero masks output", pin_out, exp_out());
        wr(a_dir(2), 32'hFFFF_FFFF);
        m_dir[2] = 32'hFFFF_FFFF;
        chk("R8 direction one exposes latch", pin_out, exp_out());

        // R6: set/clear read zero
        for (int b = 0; b < 4; b++) begin
            rd(a_set(b), d, p);
            chk("R6 set word reads zero", 128'(d), '0);
            rd(a_clr(b), d, p);
            chk("R6 clear word reads zero", 128'(d), '0);
        end

        // R7, R11, R12: level merge and notify
        pin_in = 128'h3C3C_5A5A_F00F_1234_9876_FEDC_0F0F_AAAA;
        for (int b = 0; b < 4; b++) begin
            rd(a_lvl(b), d, p);
            chk("R7 level merge", 128'(d),
                128'((m_lat[b] & m_dir[b]) | (pin_in[b*32 +: 32] & ~m_dir[b])));
            chk("R11 pulse after level read", 128'(p), 128'(1));
            @(negedge clk);
            chk("R11 pulse lasts one cycle", 128'(lvl_rd_pulse), 0);
            chk("R12 rdata holds after read", 128'(bus_rdata),
                128'((m_lat[b] & m_dir[b]) | (pin_in[b*32 +: 32] & ~m_dir[b])));
        end
        rd(a_dir(0), d, p);
        chk("R11 no pulse on direction read", 128'(p), 0);
        chk("R12 one-cycle read latency", 128'(d), 128'(m_dir[0]));

        // R10: out-of-window and unmapped offsets
        rd(AW'('h200), d, p);
        chk("R10 read at 0x200", 128'(d), 0);
        rd(AW'('h30C), d, p);
        chk("R10 read at 0x30C", 128'(d), 0);
        rd(AW'('h030), d, p);
        chk("R10 unmapped 0x030", 128'(d), 0);
        rd(AW'('h074), d, p);
        chk("R10 unmapped 0x074", 128'(d), 0);
        rd(AW'('h00D), d, p);
        chk("R10 misaligned 0x00D", 128'(d), 0);
        rd(AW'('h104), d, p);
        chk("R10 unmapped 0x104", 128'(d), 0);
        wr(AW'('h20C), 32'hDEAD_BEEF);
        wr(AW'('h218), 32'hFFFF_FFFF);
        wr(AW'('h30C), 32'h1234_5678);
        wr(AW'('h034), 32'hFFFF_FFFF);
        wr(AW'('h10D), 32'hFFFF_FFFF);
        rd(a_dir(0), d, p);
        chk("R10 stray writes leave dir0", 128'(d), 128'(m_dir[0]));
        rd(a_dir(3), d, p);
        chk("R10 stray writes leave dir3", 128'(d), 128'(m_dir[3]));
        chk("R10 stray writes leave pins", pin_out, exp_out());

        // R2: one pin at a time over all 128
        for (int b = 0; b < 4; b++) begin
            wr(a_clr(b), 32'hFFFF_FFFF); m_lat[b] = '0;
            wr(a_dir(b), 32'hFFFF_FFFF); m_dir[b] = 32'hFFFF_FFFF;
        end
        for (int n = 0; n < 128; n++) begin
            wr(a_set(n >> 5), 32'(1) << (n & 31));
            chk("R2 pin position", pin_out, 128'(1) << n);
            wr(a_clr(n >> 5), 32'(1) << (n & 31));
        end
        chk("R5 sweep leaves all clear", pin_out, '0);

        finish_run();
    end
endmodule